// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the effective address of one instruction of a small processor with 16-bit instructions. Each request gives an addressing-mode code together with the operand values that mode can use: the program counter, the stack pointer, a base register value, a short immediate field, a 13-bit prefix immediate, a software-interrupt vector number and the trap-table base register. The block answers one clock cycle later. It returns either a data address or a branch target, and a flag marks which of the two it is.

The unit also holds one piece of state, a prefix latch. A prefix request stores its 13-bit immediate in the latch. The next memory request adds that immediate as an unsigned displacement. A plain base-register access then becomes a base-plus-displacement access, and a stack-relative access can also be a store. Any request other than a prefix empties the latch. Idle cycles, where `req_valid` is low, leave it unchanged, so a stalled pipeline keeps its pending prefix.

Top module: `eagu_top`

## Requirements
- R1: After synchronous reset, `eff_valid` is 0 and no prefix is pending, so the first base-register access returns the plain base value.
- R2: Mode 2 (base-register indirect) with no pending prefix returns `req_rb` with `eff_branch` = 0.
- R3: Mode 1 (prefix) loads `req_imm13`. The following mode 2 request returns `req_rb` + zero-extended imm13, and a later one returns plain `req_rb` again. Cycles with `req_valid` low between the prefix and the access leave the latch unchanged.
- R4: Mode 3 (stack-relative) is a load when `req_store` = 0 and returns `req_sp` + zero-extended bits [6:0] of `req_imm`. As a store with no pending prefix it is rejected, and no `eff_valid` pulse follows. With a pending prefix it returns `req_sp` + imm13, whether it is a load or a store.
- R5: Mode 4 returns `req_pc` + 2 × sign-extended `req_imm`[6:0]. Mode 5 returns `req_pc` + 2 × sign-extended `req_imm`[9:0]. Both set `eff_branch` = 1, and an offset of 0x04 gives PC + 8.
- R6: Mode 6 returns `req_pc` + 2 × `req_rb` with `eff_branch` = 1.
- R7: Mode 7 returns the zero-extended `req_imm`[6:0], and mode 8 returns `req_rb`. Both set `eff_branch` = 1.
- R8: Mode 9 (software interrupt) returns the table slot address `req_ttbr` + 4 × `req_vec` with `eff_branch` = 0. For example, vector 3 gives the base + 0xC.
- R9: Modes 1, 0 and the unused codes 10 to 15 produce no `eff_valid` pulse. Every accepted request that is not a prefix, including branches and interrupts, leaves the latch empty.
- R10: All address sums wrap modulo 2^AW.
- R11: Each accepted request that produces a result raises `eff_valid` on exactly the next cycle. A cycle with `req_valid` low is followed by `eff_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle; when low, the pipeline is stalled |
| req_mode | input | 4 | Addressing-mode code, 0 to 9 as listed in the requirements |
| req_store | input | 1 | Memory request is a store (used by mode 3) |
| req_pc | input | AW | Address of the current instruction |
| req_sp | input | AW | Stack pointer |
| req_rb | input | AW | Base register value |
| req_imm | input | 10 | Short immediate field; modes 3, 4 and 7 use bits [6:0] |
| req_imm13 | input | 13 | Prefix immediate |
| req_vec | input | VEC_W | Software-interrupt vector number |
| req_ttbr | input | AW | Trap-table base register |
| eff_valid | output | 1 | Result strobe, one cycle after the request |
| eff_addr | output | AW | Effective data address or branch target |
| eff_branch | output | 1 | Result is a branch target |

## Verification
The bench targets prefix lifetime. It sends a prefix followed by idle cycles, then a prefix followed by a non-memory instruction, a branch or an unused code. A design that clears the latch on a stall would lose the displacement. One that keeps it too long would add a stale displacement to a later access. Offset signs get the same treatment: all-ones 7-bit and 10-bit fields, plus upper field bits set on a 7-bit branch, expose zero-extension or a wrong field width as targets that are far off. Sums that cross 2^24 catch a carry that is kept or truncated at the wrong width. Stack-relative stores with and without a prefix show whether the load-only restriction is enforced, and whether the prefix lifts it.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    localparam int unsigned SHORT_W = 10;
    localparam int unsigned U7_W    = 7;
    localparam int unsigned PFX_W   = 13;

    typedef enum logic [3:0] {
        MD_NONE    = 4'd0,
        MD_PREFIX  = 4'd1,
        MD_BASE    = 4'd2,
        MD_STACK   = 4'd3,
        MD_REL7    = 4'd4,
        MD_REL10   = 4'd5,
        MD_RELREG  = 4'd6,
        MD_ABSIMM  = 4'd7,
        MD_ABSREG  = 4'd8,
        MD_SWINT   = 4'd9
    } mode_e;

    function automatic logic mode_takes_prefix(input mode_e m);
        return (m == MD_BASE) || (m == MD_STACK);
    endfunction

    function automatic logic mode_is_branch(input mode_e m);
        return (m == MD_REL7) || (m == MD_REL10) || (m == MD_RELREG) ||
               (m == MD_ABSIMM) || (m == MD_ABSREG);
    endfunction

endpackage

// File: rtl/eagu_prefix_latch.sv
module eagu_prefix_latch
    import eagu_pkg::*;
#(
    parameter int unsigned IMM_W = PFX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  mode_e            mode,
    input  logic [IMM_W-1:0] imm_in,
    output logic             pend,
    output logic [IMM_W-1:0] pend_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_val <= '0;
        end else if (req_valid) begin
            if (mode == MD_PREFIX) begin
                pend     <= 1'b1;
                pend_val <= imm_in;
            end else begin
                pend     <= 1'b0;
                pend_val <= '0;
            end
        end
    end

endmodule

// File: rtl/eagu_calc.sv
module eagu_calc
    import eagu_pkg::*;
#(
    parameter int unsigned AW    = 24,
    parameter int unsigned VEC_W = 5
) (
    input  mode_e              mode,
    input  logic               is_store,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      sp,
    input  logic [AW-1:0]      rb,
    input  logic [SHORT_W-1:0] imm,
    input  logic [PFX_W-1:0]   pfx_imm,
    input  logic               pfx_pend,
    input  logic [VEC_W-1:0]   vec,
    input  logic [AW-1:0]      ttbr,
    output logic [AW-1:0]      res_addr,
    output logic               res_branch,
    output logic               res_emit
);

    localparam int unsigned PAD7  = AW - U7_W;
    localparam int unsigned PAD10 = AW - SHORT_W;
    localparam int unsigned PAD13 = AW - PFX_W;
    localparam int unsigned PADV  = AW - VEC_W;

    logic [AW-1:0] u7_z, s7_x, s10_x, pfx_z, vec_z;
    logic [AW-1:0] base_disp;

    always_comb begin
        u7_z  = {{PAD7{1'b0}}, imm[U7_W-1:0]};
        s7_x  = {{PAD7{imm[U7_W-1]}}, imm[U7_W-1:0]};
        s10_x = {{PAD10{imm[SHORT_W-1]}}, imm};
        pfx_z = {{PAD13{1'b0}}, pfx_imm};
        vec_z = {{PADV{1'b0}}, vec};
        base_disp = pfx_pend ? pfx_z : '0;
    end

    always_comb begin
        res_addr   = '0;
        res_branch = mode_is_branch(mode);
        res_emit   = 1'b1;
        unique case (mode)
            MD_BASE:   res_addr = rb + base_disp;
            MD_STACK: begin
                if (pfx_pend) begin
                    res_addr = sp + pfx_z;
                end else begin
                    res_addr = sp + u7_z;
                    res_emit = !is_store;
                end
            end
            MD_REL7:   res_addr = pc + (s7_x << 1);
            MD_REL10:  res_addr = pc + (s10_x << 1);
            MD_RELREG: res_addr = pc + (rb << 1);
            MD_ABSIMM: res_addr = u7_z;
            MD_ABSREG: res_addr = rb;
            MD_SWINT:  res_addr = ttbr + (vec_z << 2);
            default:   res_emit = 1'b0;
        endcase
    end

endmodule

// File: rtl/eagu_out_reg.sv
module eagu_out_reg #(
    parameter int unsigned AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] addr_in,
    input  logic          branch_in,
    output logic          valid_q,
    output logic [AW-1:0] addr_q,
    output logic          branch_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            addr_q   <= '0;
            branch_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) begin
                addr_q   <= addr_in;
                branch_q <= branch_in;
            end
        end
    end

endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
#(
    parameter int unsigned AW    = 24,
    parameter int unsigned VEC_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [3:0]         req_mode,
    input  logic               req_store,
    input  logic [AW-1:0]      req_pc,
    input  logic [AW-1:0]      req_sp,
    input  logic [AW-1:0]      req_rb,
    input  logic [SHORT_W-1:0] req_imm,
    input  logic [PFX_W-1:0]   req_imm13,
    input  logic [VEC_W-1:0]   req_vec,
    input  logic [AW-1:0]      req_ttbr,
    output logic               eff_valid,
    output logic [AW-1:0]      eff_addr,
    output logic               eff_branch
);

    mode_e            mode;
    logic             pfx_pend;
    logic [PFX_W-1:0] pfx_val;
    logic [AW-1:0]    calc_addr;
    logic             calc_branch;
    logic             calc_emit;

    assign mode = mode_e'(req_mode);

    eagu_prefix_latch #(.IMM_W(PFX_W)) u_pfx (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .mode      (mode),
        .imm_in    (req_imm13),
        .pend      (pfx_pend),
        .pend_val  (pfx_val)
    );

    eagu_calc #(.AW(AW), .VEC_W(VEC_W)) u_calc (
        .mode       (mode),
        .is_store   (req_store),
        .pc         (req_pc),
        .sp         (req_sp),
        .rb         (req_rb),
        .imm        (req_imm),
        .pfx_imm    (pfx_val),
        .pfx_pend   (pfx_pend && mode_takes_prefix(mode)),
        .vec        (req_vec),
        .ttbr       (req_ttbr),
        .res_addr   (calc_addr),
        .res_branch (calc_branch),
        .res_emit   (calc_emit)
    );

    eagu_out_reg #(.AW(AW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .take      (req_valid && calc_emit),
        .addr_in   (calc_addr),
        .branch_in (calc_branch),
        .valid_q   (eff_valid),
        .addr_q    (eff_addr),
        .branch_q  (eff_branch)
    );

endmodule

// File: rtl/eagu_chk.sv
module eagu_chk #(
    parameter int unsigned AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [3:0]    req_mode,
    input logic          pc_lsb,
    input logic [1:0]    ttbr_lsbs,
    input logic [AW-1:0] req_rb,
    input logic          eff_valid,
    input logic [AW-1:0] eff_addr,
    input logic          eff_branch,
    input logic          pend,
    input logic [12:0]   pend_val
);

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        eff_valid |-> $past(req_valid));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !eff_valid);

    p_prefix_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd1) |=> !eff_valid);

    p_latch_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode != 4'd1) |=> !pend);

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(pend) && $stable(pend_val)));

    p_plain_base_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd2 && !pend) |=>
            (eff_valid && !eff_branch && eff_addr == $past(req_rb)));

    p_rel_parity_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_mode == 4'd4 || req_mode == 4'd5 || req_mode == 4'd6)) |=>
            (eff_valid && eff_branch && eff_addr[0] == $past(pc_lsb)));

    p_abs_imm_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd7) |=>
            (eff_valid && eff_branch && eff_addr[AW-1:7] == '0));

    p_abs_reg_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd8) |=>
            (eff_valid && eff_branch && eff_addr == $past(req_rb)));

    p_swint_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd9) |=>
            (eff_valid && !eff_branch && eff_addr[1:0] == $past(ttbr_lsbs)));

endmodule

bind eagu_top eagu_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .pc_lsb     (req_pc[0]),
    .ttbr_lsbs  (req_ttbr[1:0]),
    .req_rb     (req_rb),
    .eff_valid  (eff_valid),
    .eff_addr   (eff_addr),
    .eff_branch (eff_branch),
    .pend       (pfx_pend),
    .pend_val   (pfx_val)
);

// File: tb/eagu_top_tb_top.sv
module eagu_top_tb_top;

    localparam int AW = 24;

    typedef struct {
        logic          v;
        logic [AW-1:0] a;
        logic          b;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    req_mode = '0;
    logic          req_store = 1'b0;
    logic [AW-1:0] req_pc = '0, req_sp = '0, req_rb = '0, req_ttbr = '0;
    logic [9:0]    req_imm = '0;
    logic [12:0]   req_imm13 = '0;
    logic [4:0]    req_vec = '0;
    logic          eff_valid, eff_branch;
    logic [AW-1:0] eff_addr;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    eagu_top #(.AW(AW), .VEC_W(5)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_store(req_store), .req_pc(req_pc), .req_sp(req_sp), .req_rb(req_rb),
        .req_imm(req_imm), .req_imm13(req_imm13), .req_vec(req_vec),
        .req_ttbr(req_ttbr), .eff_valid(eff_valid), .eff_addr(eff_addr),
        .eff_branch(eff_branch)
    );

    function automatic logic [AW-1:0] sx7(input logic [9:0] f);
        return {{(AW-7){f[6]}}, f[6:0]};
    endfunction

    function automatic logic [AW-1:0] sx10(input logic [9:0] f);
        return {{(AW-10){f[9]}}, f};
    endfunction

    task automatic drive(input logic [3:0] m, input logic st, input logic [AW-1:0] pc,
                         input logic [AW-1:0] sp, input logic [AW-1:0] rb,
                         input logic [9:0] imm, input logic [12:0] i13,
                         input logic [4:0] vec, input logic [AW-1:0] tt,
                         input logic ev, input logic [AW-1:0] ea, input logic eb,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_store = st; req_pc = pc; req_sp = sp;
        req_rb = rb; req_imm = imm; req_imm13 = i13; req_vec = vec; req_ttbr = tt;
        e.v = ev; e.a = ea; e.b = eb; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            req_valid = 1'b0;
            req_mode = 4'd2; req_rb = 24'hDEAD00; req_imm13 = 13'h1ABC;
            e.v = 1'b0; e.a = '0; e.b = 1'b0; e.tag = tag;
            q.push_back(e);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (eff_valid !== e.v) begin
                errors++;
                $display("FAIL %s: eff_valid=%0b expected %0b", e.tag, eff_valid, e.v);
            end else if (e.v && (eff_addr !== e.a || eff_branch !== e.b)) begin
                errors++;
                $display("FAIL %s: addr=%06h br=%0b expected addr=%06h br=%0b",
                         e.tag, eff_addr, eff_branch, e.a, e.b);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired with %0d items pending", q.size());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (eff_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: eff_valid=%0b during reset expected 0", eff_valid);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: first access after reset, no prefix pending
        drive(4'd2, 0, 0, 0, 24'h123456, 0, 13'h1FFF, 0, 0, 1, 24'h123456, 0, "R1 R2 base after reset");
        // R3: prefix then base, then plain again
        drive(4'd1, 0, 0, 0, 0, 0, 13'h1FFF, 0, 0, 0, 0, 0, "R9 prefix silent");
        drive(4'd2, 0, 0, 0, 24'h001000, 0, 0, 0, 0, 1, 24'h002FFF, 0, "R3 base+imm13");
        drive(4'd2, 0, 0, 0, 24'h001000, 0, 0, 0, 0, 1, 24'h001000, 0, "R3 prefix consumed");
        // R3: prefix held across stall cycles
        drive(4'd1, 0, 0, 0, 0, 0, 13'h0100, 0, 0, 0, 0, 0, "R9 prefix silent");
        idle(3, "R11 stall quiet");
        drive(4'd2, 0, 0, 0, 24'h000010, 0, 0, 0, 0, 1, 24'h000110, 0, "R3 prefix held over stall");
        // R4: stack-relative
        drive(4'd3, 0, 0, 24'h008000, 0, 10'h07F, 0, 0, 0, 1, 24'h00807F, 0, "R4 stack load");
        drive(4'd3, 1, 0, 24'h008000, 0, 10'h07F, 0, 0, 0, 0, 0, 0, "R4 stack store rejected");
        drive(4'd1, 0, 0, 0, 0, 0, 13'h0040, 0, 0, 0, 0, 0, "R9 prefix silent");
        drive(4'd3, 1, 0, 24'h008000, 0, 10'h07F, 0, 0, 0, 1, 24'h008040, 0, "R4 stack store with prefix");
        // R5: relative branches
        drive(4'd4, 0, 24'h001000, 0, 0, 10'h384, 0, 0, 0, 1, 24'h001008, 1, "R5 rel7 0x04 gives pc+8");
        drive(4'd4, 0, 24'h001000, 0, 0, 10'h07F, 0, 0, 0, 1, 24'h001000 + (sx7(10'h07F) << 1), 1, "R5 rel7 minus one");
        drive(4'd5, 0, 24'h001000, 0, 0, 10'h200, 0, 0, 0, 1, 24'h001000 + (sx10(10'h200) << 1), 1, "R5 rel10 most negative");
        drive(4'd5, 0, 24'h001000, 0, 0, 10'h1FF, 0, 0, 0, 1, 24'h0013FE, 1, "R5 rel10 most positive");
        // R6, R7
        drive(4'd6, 0, 24'h000100, 0, 24'h000010, 0, 0, 0, 0, 1, 24'h000120, 1, "R6 pc+2*rb");
        drive(4'd7, 0, 24'h555555, 0, 0, 10'h3FF, 0, 0, 0, 1, 24'h00007F, 1, "R7 absolute imm7");
        drive(4'd8, 0, 24'h555555, 0, 24'hABCDEF, 0, 0, 0, 0, 1, 24'hABCDEF, 1, "R7 absolute rb");
        // R8: interrupt vector slots
        drive(4'd9, 0, 0, 0, 0, 0, 0, 5'd3, 24'h020000, 1, 24'h02000C, 0, "R8 vector 3");
        drive(4'd9, 0, 0, 0, 0, 0, 0, 5'd31, 24'h020000, 1, 24'h02007C, 0, "R8 vector 31");
        // R9: prefix cleared by non-memory, branch, unused code
        drive(4'd1, 0, 0, 0, 0, 0, 13'h0055, 0, 0, 0, 0, 0, "R9 prefix silent");
        drive(4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 none silent");
        drive(4'd2, 0, 0, 0, 24'h000008, 0, 13'h0055, 0, 0, 1, 24'h000008, 0, "R9 cleared by none");
        drive(4'd1, 0, 0, 0, 0, 0, 13'h0055, 0, 0, 0, 0, 0, "R9 prefix silent");
        drive(4'd4, 0, 24'h000200, 0, 0, 10'h002, 0, 0, 0, 1, 24'h000204, 1, "R9 branch ignores prefix");
        drive(4'd2, 0, 0, 0, 24'h000008, 0, 0, 0, 0, 1, 24'h000008, 0, "R9 cleared by branch");
        drive(4'd1, 0, 0, 0, 0, 0, 13'h0055, 0, 0, 0, 0, 0, "R9 prefix silent");
        drive(4'd15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 unused code silent");
        drive(4'd2, 0, 0, 0, 24'h000008, 0, 0, 0, 0, 1, 24'h000008, 0, "R9 cleared by unused code");
        // R10: wrap-around
        drive(4'd1, 0, 0, 0, 0, 0, 13'h0002, 0, 0, 0, 0, 0, "R9 prefix silent");
        drive(4'd2, 0, 0, 0, 24'hFFFFFF, 0, 0, 0, 0, 1, 24'h000001, 0, "R10 base wraps");
        drive(4'd4, 0, 24'h000002, 0, 0, 10'h07E, 0, 0, 0, 1, 24'hFFFFFE, 1, "R10 rel7 wraps below zero");
        drive(4'd9, 0, 0, 0, 0, 0, 0, 5'd1, 24'hFFFFFC, 1, 24'h000000, 0, "R10 vector slot wraps");
        idle(3, "R11 trailing quiet");
        @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d results outstanding expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule